// File: doc/BRIEF.md
# Synchronous Serial Port Controller

This block is a register-mapped controller for a synchronous serial port, seen by software through a small 32-bit read/write bus. Software writes words into an eight-entry transmit queue. A transfer engine sends them one at a time over a word-level exchange handshake and places each returned word into an eight-entry receive queue, which software drains by reading the data register. A loopback mode sends each word straight back into the receive queue and leaves the external handshake idle.

Every word is cut to a programmable frame size of 1 to 16 bits. This applies to words written into the transmit queue and to words placed into the receive queue. The engine never overruns the receive queue. When that queue is full the engine waits, and it carries on in the cycle after software has freed a slot. Status flags show the queue levels. Two level-based interrupt sources are combined through a mask into a single interrupt line.

Serial bit timing, prescaler behaviour, DMA and slave operation are not modelled. The related fields are stored so that software can read them back, but they have no effect.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset both queues are empty, the status register (offset 0x0C) reads 0x03, the raw interrupt register (0x18) reads 0x08, the interrupt mask (0x14) reads 0 and `irq` is low.
- R2: Control register 0 (offset 0x00) bits [3:0] hold N, and the frame size is N+1 bits. Words written to the data register (0x08) are masked to that size, and so is every word pushed into the receive queue.
- R3: When control register 1 (0x04) has bit 0 (loopback) and bit 1 (enable) set, each transmit word is pushed into the receive queue, and `xchg_valid` stays low.
- R4: With enable set and loopback clear, the head transmit word is presented on `xchg_tx` with `xchg_valid`. It is held steady until `xchg_ready` is high, and in that cycle `xchg_rx` (masked) is pushed into the receive queue. At most one word moves per clock.
- R5: While control register 1 bit 1 is clear, no word is transferred and `xchg_valid` is low.
- R6: While the receive queue holds 8 words the engine stalls. A data-register read frees a slot in the cycle of the read, and the stalled transfer resumes on the next clock.
- R7: Status bits: bit 0 = transmit queue empty, bit 1 = transmit queue not full, bit 2 = receive queue not empty, bit 3 = receive queue full, bit 4 = busy (transmit queue not empty).
- R8: Raw interrupt bit 2 is set while the receive queue holds 4 or more words, and bit 3 is set while the transmit queue holds 4 or fewer. Offset 0x1C reads raw AND mask, and `irq` is high when that value is non-zero.
- R9: A data-register read with an empty receive queue returns 0 and changes nothing. A data-register write with a full transmit queue is discarded.
- R10: Offsets 0xFE0 to 0xFFC return, one byte per word step, the identification bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Offset 0x10 stores and returns the low 8 bits written to it. Offset 0x20 always reads 0.
- R12: Both queues keep first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at the data offset) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Combined masked interrupt |
| xchg_valid | output | 1 | Transmit word offered to the exchange |
| xchg_tx | output | 16 | Word being offered |
| xchg_ready | input | 1 | Exchange accepts the word and supplies the response |
| xchg_rx | input | 16 | Response word |

## Verification
A queue pointer or count that goes wrong shows at the status register and raw interrupt bits one clock later. It also shows in the data returned by the next data-register read, because the order and masking of words is compared against the values written. An engine that ignores the stall rule or the enable bit shows on `xchg_valid` and on the receive level as soon as software fills or drains the queues. A broken hold of `xchg_tx` under back-pressure shows in the cycle after the offer.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int ADDR_W = 12;
    localparam int BUS_W  = 32;
    localparam int WORD_W = 16;
    localparam int SIZE_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL0 = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CTRL1 = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_PRESC = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_IMASK = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_MIS   = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_DMA   = 12'h020;
    localparam logic [6:0]        ID_PAGE   = 7'h7F;

    typedef struct packed {
        logic slave_quiet;
        logic slave_sel;
        logic enable;
        logic loopback;
    } ctrl1_t;

    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_nonempty;
        logic tx_notfull;
        logic tx_empty;
    } status_t;

    typedef struct packed {
        logic       tx_low;
        logic       rx_high;
        logic [1:0] rsvd;
    } irq_vec_t;

    function automatic logic [WORD_W-1:0] size_mask(input logic [SIZE_W-1:0] n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i <= int'(n)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h22;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_data = mem[rptr];
    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R12
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
    import ssp_pkg::*;
(
    input  logic              enable,
    input  logic              loopback,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic [WORD_W-1:0] tx_head,
    input  logic [WORD_W-1:0] frame_mask,
    input  logic              xchg_ready,
    input  logic [WORD_W-1:0] xchg_rx,
    output logic              xchg_valid,
    output logic [WORD_W-1:0] xchg_tx,
    output logic              move,
    output logic [WORD_W-1:0] rx_word
);
    logic can_go;

    assign can_go     = enable & ~tx_empty & ~rx_full;
    assign xchg_valid = can_go & ~loopback;
    assign xchg_tx    = tx_head;
    assign move       = can_go & (loopback | xchg_ready);
    assign rx_word    = (loopback ? tx_head : xchg_rx) & frame_mask;

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              xchg_valid,
    output logic [WORD_W-1:0] xchg_tx,
    input  logic              xchg_ready,
    input  logic [WORD_W-1:0] xchg_rx
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

    logic [WORD_W-1:0] ctrl0;
    ctrl1_t            ctrl1;
    logic [7:0]        presc;
    logic [3:0]        imask;

    logic [WORD_W-1:0] frame_mask;
    logic              wr_data, rd_data;
    logic              tx_push, tx_pop, tx_empty, tx_full;
    logic              rx_push, rx_pop, rx_empty, rx_full;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    status_t           stat;
    irq_vec_t          raw;
    logic              wire_unused;

    assign wire_unused = ^bus_wdata[BUS_W-1:WORD_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0 <= '0;
            ctrl1 <= '0;
            presc <= '0;
            imask <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL0: ctrl0 <= bus_wdata[WORD_W-1:0];
                OFS_CTRL1: ctrl1 <= ctrl1_t'(bus_wdata[3:0]);
                OFS_PRESC: presc <= bus_wdata[7:0];
                OFS_IMASK: imask <= bus_wdata[3:0];
                default:   ;
            endcase
        end
    end

    assign frame_mask = size_mask(ctrl0[SIZE_W-1:0]);
    assign wr_data    = bus_wr && (bus_addr == OFS_DATA);
    assign rd_data    = bus_rd && (bus_addr == OFS_DATA);
    assign tx_push    = wr_data && !tx_full;
    assign rx_pop     = rd_data && !rx_empty;

    ssp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) tx_q_i (
        .clk(clk), .rst(rst),
        .push(tx_push), .push_data(bus_wdata[WORD_W-1:0] & frame_mask),
        .pop(tx_pop), .head_data(tx_head),
        .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    ssp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) rx_q_i (
        .clk(clk), .rst(rst),
        .push(rx_push), .push_data(rx_word),
        .pop(rx_pop), .head_data(rx_head),
        .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    ssp_engine engine_i (
        .enable(ctrl1.enable), .loopback(ctrl1.loopback),
        .tx_empty(tx_empty), .rx_full(rx_full),
        .tx_head(tx_head), .frame_mask(frame_mask),
        .xchg_ready(xchg_ready), .xchg_rx(xchg_rx),
        .xchg_valid(xchg_valid), .xchg_tx(xchg_tx),
        .move(tx_pop), .rx_word(rx_word)
    );

    assign rx_push = tx_pop;

    always_comb begin
        stat.tx_empty    = tx_empty;
        stat.tx_notfull  = !tx_full;
        stat.rx_nonempty = !rx_empty;
        stat.rx_full     = rx_full;
        stat.busy        = !tx_empty;
        raw.tx_low       = (tx_cnt <= HALF);
        raw.rx_high      = (rx_cnt >= HALF);
        raw.rsvd         = 2'b00;
    end

    assign irq = |(raw & imask);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[ADDR_W-1:5] == ID_PAGE) begin
            bus_rdata = BUS_W'(id_byte(bus_addr[4:2]));
        end else begin
            case (bus_addr)
                OFS_CTRL0: bus_rdata = BUS_W'(ctrl0);
                OFS_CTRL1: bus_rdata = BUS_W'(ctrl1);
                OFS_DATA:  bus_rdata = rx_empty ? '0 : BUS_W'(rx_head);
                OFS_STAT:  bus_rdata = BUS_W'(stat);
                OFS_PRESC: bus_rdata = BUS_W'(presc);
                OFS_IMASK: bus_rdata = BUS_W'(imask);
                OFS_RAW:   bus_rdata = BUS_W'(raw);
                OFS_MIS:   bus_rdata = BUS_W'(raw & imask);
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R4
    xchg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xchg_valid && !xchg_ready && !(bus_wr && bus_addr == OFS_CTRL1))
        |=> (xchg_valid && $stable(xchg_tx)));

    // R5
    xchg_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL1 && !bus_wdata[1]) |=> !xchg_valid);

    // R9
    full_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_data && tx_full && !tx_pop) |=> tx_full);

endmodule

// File: tb/ssp_ctrl_tb.sv
`timescale 1ns/1ps
module ssp_ctrl_tb_top;
    import ssp_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic              irq;
    logic              xchg_valid;
    logic [WORD_W-1:0] xchg_tx;
    logic              xchg_ready = 1'b0;
    logic [WORD_W-1:0] xchg_rx;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    // Responder: returns the offered word with a fixed pattern flipped.
    assign xchg_rx = xchg_tx ^ 16'hA5A5;

    ssp_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .xchg_valid(xchg_valid), .xchg_tx(xchg_tx),
        .xchg_ready(xchg_ready), .xchg_rx(xchg_rx)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic        chk;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h00C, 32'h0000_0003, 1'b1, 8'd1},   // R1 status
        '{1'b0, 12'h018, 32'h0000_0008, 1'b1, 8'd1},   // R1 raw
        '{1'b0, 12'h014, 32'h0000_0000, 1'b1, 8'd1},   // R1 mask
        '{1'b1, 12'h000, 32'h0000_0007, 1'b0, 8'd2},   // R2 8-bit frames
        '{1'b1, 12'h004, 32'h0000_0003, 1'b0, 8'd3},   // R3 loopback+enable
        '{1'b1, 12'h008, 32'h0000_01AB, 1'b0, 8'd2},
        '{1'b1, 12'h008, 32'h0000_00CD, 1'b0, 8'd2},
        '{1'b0, 12'h00C, 32'h0000_0007, 1'b1, 8'd7},   // R7
        '{1'b0, 12'h008, 32'h0000_00AB, 1'b1, 8'd2},   // R2 R3
        '{1'b0, 12'h008, 32'h0000_00CD, 1'b1, 8'd12},  // R12
        '{1'b0, 12'h008, 32'h0000_0000, 1'b1, 8'd9},   // R9 empty read
        '{1'b0, 12'h00C, 32'h0000_0003, 1'b1, 8'd9},   // R9 no side effect
        '{1'b0, 12'hFE0, 32'h0000_0022, 1'b1, 8'd10},  // R10
        '{1'b0, 12'hFF0, 32'h0000_000D, 1'b1, 8'd10},
        '{1'b0, 12'hFFC, 32'h0000_00B1, 1'b1, 8'd10},
        '{1'b1, 12'h010, 32'h0000_01FF, 1'b0, 8'd11},  // R11
        '{1'b0, 12'h010, 32'h0000_00FF, 1'b1, 8'd11},
        '{1'b0, 12'h020, 32'h0000_0000, 1'b1, 8'd11},
        '{1'b0, 12'h000, 32'h0000_0007, 1'b1, 8'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        do_reset();
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].addr, VECS[i].data);
            end else begin
                rd(VECS[i].addr, v);
                if (VECS[i].chk)
                    check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].data);
            end
            idle(2);
        end

        // R5: disabled port holds words; R8 thresholds and mask
        do_reset();
        wr(12'h000, 32'hF);
        wr(12'h004, 32'h0);
        wr(12'h008, 32'h1111);
        wr(12'h008, 32'h2222);
        wr(12'h008, 32'h3333);
        idle(3);
        check("R5 valid low", {31'b0, xchg_valid}, 32'h0);
        rd(12'h00C, v); check("R5 R7 status", v, 32'h12);
        rd(12'h018, v); check("R8 raw tx low", v, 32'h08);
        wr(12'h014, 32'h8);
        #1 check("R8 irq on", {31'b0, irq}, 32'h1);
        rd(12'h01C, v); check("R8 masked", v, 32'h08);
        wr(12'h008, 32'h4444);
        wr(12'h008, 32'h5555);
        rd(12'h018, v); check("R8 raw none", v, 32'h00);
        #1 check("R8 irq off", {31'b0, irq}, 32'h0);

        // R4: offer held under back-pressure
        wr(12'h004, 32'h2);
        idle(1);
        check("R4 valid", {31'b0, xchg_valid}, 32'h1);
        check("R4 head word", {16'b0, xchg_tx}, 32'h1111);
        idle(3);
        check("R4 still held", {16'b0, xchg_tx}, 32'h1111);
        rd(12'h00C, v); check("R4 nothing moved", v, 32'h12);
        xchg_ready = 1'b1;
        idle(8);
        xchg_ready = 1'b0;
        rd(12'h00C, v); check("R4 R7 drained", v, 32'h07);
        rd(12'h018, v); check("R8 raw both", v, 32'h0C);
        wr(12'h014, 32'h4);
        rd(12'h01C, v); check("R8 masked rx", v, 32'h04);
        rd(12'h008, v); check("R4 resp 0", v, 32'h1111 ^ 32'hA5A5);
        rd(12'h008, v); check("R12 resp 1", v, 32'h2222 ^ 32'hA5A5);
        rd(12'h008, v); check("R12 resp 2", v, 32'h3333 ^ 32'hA5A5);
        rd(12'h008, v); check("R12 resp 3", v, 32'h4444 ^ 32'hA5A5);
        rd(12'h008, v); check("R12 resp 4", v, 32'h5555 ^ 32'hA5A5);

        // R2: mask on both sides of the exchange
        wr(12'h000, 32'h7);
        xchg_ready = 1'b1;
        wr(12'h008, 32'h3312);
        idle(2);
        xchg_ready = 1'b0;
        rd(12'h008, v); check("R2 rx masked", v, 32'h00B7);

        // R6: stall on full receive queue, resume after a read
        do_reset();
        wr(12'h000, 32'hF);
        wr(12'h004, 32'h3);
        for (int k = 0; k < 16; k++) wr(12'h008, 32'h100 + k);
        wr(12'h008, 32'hDEAD);
        idle(3);
        rd(12'h00C, v); check("R6 R7 both full", v, 32'h1C);
        check("R3 no external offer", {31'b0, xchg_valid}, 32'h0);
        rd(12'h008, v); check("R6 first", v, 32'h100);
        idle(2);
        rd(12'h00C, v); check("R6 resumed", v, 32'h1E);
        for (int k = 1; k < 16; k++) begin
            rd(12'h008, v);
            check($sformatf("R12 drain %0d", k), v, 32'h100 + k);
            idle(1);
        end
        rd(12'h008, v); check("R9 full write dropped", v, 32'h0);
        rd(12'h00C, v); check("R6 idle status", v, 32'h03);

        finish_run();
    end

endmodule